// File: doc/BRIEF.md
# Codec Serial FIFO Interface

This block connects a processor bus to a serial sound codec. A write strobe on the 8-bit data port places a byte into a 16-entry transmit queue. A read strobe takes the oldest byte from a 16-entry receive queue. A serial engine runs on its own. It divides the system clock into a bit clock and moves one byte in each direction per frame, most significant bit first. A frame sync marks the first bit of every frame.

A periodic interrupt pulses once every eight frames, whatever the queue levels are. With the bit divider chosen so that frames run at 8000 per second, the interrupt arrives at 1 kHz. Software polls four level flags (transmit empty and full, receive empty and full) and two sticky error flags. Transmit underrun is set when a frame had no byte to send. Receive overrun is set when a received byte found the queue full. Both error flags clear only on reset.

Top module: `codec_fifo_link`

## Requirements
- R1: After reset, tx_empty and rx_empty are 1. tx_full, rx_full, tx_underrun, rx_overrun, irq and fsync are 0, and rd_data is 0x00.
- R2: Bytes written with wr_en leave on sdout in write order, one byte per frame, most significant bit first.
- R3: A write while tx_full is 1 is dropped: that byte is never sent.
- R4: A frame is 8 bits of BIT_DIV clocks each. The first frame starts on the clock edge that ends BIT_DIV cycles after reset is released. fsync is 1 for the whole first bit of a frame and 0 for the other seven bits.
- R5: If the transmit queue is empty when a frame starts, the frame sends 0x00 and tx_underrun goes to 1. tx_underrun stays at 1 until reset.
- R6: sdin is sampled on the clock edge that ends each bit, most significant bit first. The byte is queued at the end of its frame. A rd_en pulse puts the oldest queued byte on rd_data one clock later.
- R7: A byte that completes while rx_full is 1 is dropped and rx_overrun goes to 1. rx_overrun stays at 1 until reset.
- R8: A read while rx_empty is 1 leaves rd_data unchanged and does not disturb the queue.
- R9: irq is a one-cycle pulse in the first cycle after every eighth completed frame. It counts frames since reset, including frames whose byte was dropped.
- R10: The level flags follow the queue counts: empty at 0 entries, full at DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to queue for transmission |
| rd_en | input | 1 | Read strobe for the data register |
| rd_data | output | 8 | Last byte taken from the receive queue |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_full | output | 1 | Transmit queue holds DEPTH bytes |
| rx_empty | output | 1 | Receive queue holds no byte |
| rx_full | output | 1 | Receive queue holds DEPTH bytes |
| tx_underrun | output | 1 | Sticky: a frame started with nothing to send |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |
| irq | output | 1 | One-cycle pulse every eighth frame |
| sclk | output | 1 | Bit clock to the codec, high in the first half of each bit |
| fsync | output | 1 | High during the first bit of each frame |
| sdout | output | 1 | Serial data to the codec |
| sdin | input | 1 | Serial data from the codec |

## Verification
The bench fills the transmit queue while the first frame has already taken a byte. It then checks that the seventeenth accepted byte is sent and the eighteenth is not. A design that tested fullness wrongly would either send the extra byte or lose one. The bench also checks that a frame with an empty queue sends zero and raises the sticky underrun flag at the right frame, not one frame early or late.

On the receive side, the bench reads an empty queue and then checks that the next real byte still comes out correctly. A design that moved the read pointer on an empty read would return stale data or drop the byte. The bench lets sixteen bytes fill the receive queue and confirms that the seventeenth is discarded, not written over the oldest. It also checks that the interrupt lands only after frames eight and sixteen, which catches a counter that is off by one or that skips dropped frames.

// File: rtl/codec_fifo_link.sv
module codec_fifo_link #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 16,
  parameter int BIT_DIV   = 4,
  parameter int IRQ_EVERY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_underrun,
  output logic             rx_overrun,
  output logic             irq,
  output logic             sclk,
  output logic             fsync,
  output logic             sdout,
  input  logic             sdin
);
  localparam int AW = $clog2(DEPTH);
  localparam int DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam int BW = $clog2(WIDTH);
  localparam int IW = (IRQ_EVERY > 1) ? $clog2(IRQ_EVERY) : 1;

  logic [DW-1:0]    div_q;
  logic [BW-1:0]    bit_q;
  logic             primed_q;
  logic [WIDTH-1:0] tx_sh, rx_sh;
  logic [IW-1:0]    xfer_q;

  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW:0]      tx_wp, tx_rp, rx_wp, rx_rp;

  wire tick       = div_q == DW'(BIT_DIV - 1);
  wire frame_edge = tick && bit_q == BW'(WIDTH - 1);
  wire byte_done  = frame_edge && primed_q;
  wire [WIDTH-1:0] rx_byte = {rx_sh[WIDTH-2:0], sdin};

  wire [AW:0] tx_cnt = tx_wp - tx_rp;
  wire [AW:0] rx_cnt = rx_wp - rx_rp;
  assign tx_empty = tx_cnt == '0;
  assign tx_full  = tx_cnt == (AW+1)'(DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt == (AW+1)'(DEPTH);

  wire tx_push = wr_en && !tx_full;
  wire tx_pop  = frame_edge && !tx_empty;
  wire rx_push = byte_done && !rx_full;
  wire rx_pop  = rd_en && !rx_empty;

  assign fsync = primed_q && bit_q == '0;
  assign sclk  = primed_q && div_q < DW'(BIT_DIV / 2);
  assign sdout = tx_sh[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      bit_q    <= BW'(WIDTH - 1);
      primed_q <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        rx_sh <= rx_byte;
        if (frame_edge) begin
          bit_q    <= '0;
          primed_q <= 1'b1;
          tx_sh    <= tx_empty ? '0 : tx_mem[tx_rp[AW-1:0]];
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_sh <= {tx_sh[WIDTH-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= wr_data;
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp       <= '0;
      tx_rp       <= '0;
      rx_wp       <= '0;
      rx_rp       <= '0;
      rd_data     <= '0;
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
      xfer_q      <= '0;
      irq         <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop) begin
        rx_rp   <= rx_rp + 1'b1;
        rd_data <= rx_mem[rx_rp[AW-1:0]];
      end
      if (frame_edge && tx_empty) tx_underrun <= 1'b1;
      if (byte_done && rx_full)   rx_overrun  <= 1'b1;
      irq <= byte_done && xfer_q == IW'(IRQ_EVERY - 1);
      if (byte_done)
        xfer_q <= (xfer_q == IW'(IRQ_EVERY - 1)) ? '0 : xfer_q + 1'b1;
    end
  end
endmodule

// File: rtl/codec_fifo_link_chk.sv
module codec_fifo_link_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             tx_underrun,
  input logic             rx_overrun,
  input logic             irq,
  input logic             fsync,
  input logic             tx_pop
);
  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en && tx_full && !tx_pop |=> tx_full); // R3
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) rd_en && rx_empty |=> $stable(rd_data) && rx_empty); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R9
  AST_IRQ_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $rose(fsync)); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) tx_underrun |=> tx_underrun); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rx_overrun |=> rx_overrun); // R7
  AST_FLAG_PAIRS: assert property (@(posedge clk) disable iff (!rst_n) !(tx_empty && tx_full) && !(rx_empty && rx_full)); // R10
endmodule

bind codec_fifo_link codec_fifo_link_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
  .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .irq(irq), .fsync(fsync),
  .tx_pop(tx_pop)
);

// File: tb/tb_codec_fifo_link.sv
`timescale 1ns/100ps
module tb_codec_fifo_link;
  localparam int BIT_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sdin = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_underrun, rx_overrun;
  logic irq, sclk, fsync, sdout;
  logic fs_q = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  codec_fifo_link #(.WIDTH(8), .DEPTH(16), .BIT_DIV(BIT_DIV), .IRQ_EVERY(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_full(rx_full), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .irq(irq),
    .sclk(sclk), .fsync(fsync), .sdout(sdout), .sdin(sdin)
  );

  initial forever #2.5 clk = ~clk;
  always @(posedge clk) fs_q <= fsync;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; sdin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic get_frame(input logic [7:0] rxb, output logic [7:0] txb, output bit fs_ok);
    while (!(fsync && !fs_q)) @(negedge clk);
    fs_ok = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (b > 0) begin
        repeat (BIT_DIV) @(negedge clk);
        if (fsync) fs_ok = 1'b0;
      end
      sdin = rxb[7-b];
      txb[7-b] = sdout;
    end
    repeat (BIT_DIV) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 tx_empty", tx_empty, 1);
    check("R1 tx_full", tx_full, 0);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 rx_full", rx_full, 0);
    check("R1 sticky", {tx_underrun, rx_overrun}, 0);
    check("R1 irq/fsync", {irq, fsync}, 0);
    check("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_tx_order();
    logic [7:0] got;
    logic [7:0] src [3] = '{8'hA5, 8'h3C, 8'h81};
    bit ok;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_data = src[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R10 tx_empty after writes", tx_empty, 0);
    check("R10 tx_full after writes", tx_full, 0);
    for (int i = 0; i < 3; i++) begin
      get_frame(8'h00, got, ok);
      check("R2 byte order", got, src[i]);
      check("R4 fsync shape", ok, 1);
      if (i == 1) check("R5 no underrun yet", tx_underrun, 0);
    end
    check("R5 underrun set", tx_underrun, 1);
    check("R10 tx_empty drained", tx_empty, 1);
    get_frame(8'h00, got, ok);
    check("R5 zero byte", got, 8'h00);
    check("R5 underrun sticky", tx_underrun, 1);
  endtask

  task automatic t_tx_full();
    logic [7:0] got;
    bit ok;
    do_reset();
    for (int i = 0; i < 18; i++) begin
      wr_en = 1'b1; wr_data = 8'(8'h10 + i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R3 tx_full", tx_full, 1);
    for (int k = 2; k <= 18; k++) begin
      get_frame(8'h00, got, ok);
      if (k <= 17) check("R3 accepted byte", got, 8'(8'h10 + k - 1));
      else         check("R3 dropped byte not sent", got, 8'h00);
    end
  endtask

  task automatic t_rx();
    logic [7:0] got;
    logic [7:0] src [3] = '{8'hC3, 8'h5A, 8'h01};
    bit ok;
    do_reset();
    for (int i = 0; i < 3; i++) get_frame(src[i], got, ok);
    check("R10 rx_empty with data", rx_empty, 0);
    for (int i = 0; i < 3; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
      check("R6 received byte", rd_data, src[i]);
    end
    rd_en = 1'b0;
    check("R10 rx_empty drained", rx_empty, 1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 empty read keeps data", rd_data, 8'h01);
    check("R8 still empty", rx_empty, 1);
    repeat (40) @(negedge clk);
    check("R8 next byte arrived", rx_empty, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 next byte intact", rd_data, 8'hFF);
  endtask

  task automatic t_overrun_irq();
    logic [7:0] got;
    bit ok;
    do_reset();
    for (int i = 0; i < 17; i++) begin
      get_frame(8'(i + 1), got, ok);
      check("R9 irq after frame", irq, (i == 7 || i == 15) ? 1 : 0);
      if (i == 15) begin
        check("R7 rx_full at 16", rx_full, 1);
        check("R7 no overrun yet", rx_overrun, 0);
      end
    end
    check("R7 overrun set", rx_overrun, 1);
    check("R7 still full", rx_full, 1);
    for (int i = 0; i < 16; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
      check("R7 kept bytes", rd_data, 8'(i + 1));
    end
    rd_en = 1'b0;
    check("R7 dropped byte absent", rx_empty, 1);
    check("R9 irq low later", irq, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_overrun_irq();
    finish_run();
  end
endmodule